// File: doc/BRIEF.md
# Guarded Watchdog Counter

This block is a watchdog down-counter whose reload value is spread over several byte registers on a small write bus. The reload bytes are write-protected: software must first write a two-byte key to the control address and then write the reload bytes strictly from most significant to least significant. Any write that does not fit that pattern relocks the protection. Once the last byte is written, the protection relocks by itself.

The counter takes the reload value when the watchdog is switched on and whenever the refresh pulse arrives. It counts down once per tick while enabled. A tick that finds the counter at zero is a time-out. Depending on the mode input, a time-out raises either an interrupt request or a reset request. In reset mode the request is a normal reset when the stop input is low and a stop-recovery request when it is high. The matching status flags show in the control register and are cleared when software reads that register.

Top module: `wdog_guard`

## Requirements
- R1: After reset every reload byte reads 0xFF, the control register (address 0) reads 0x00, the protection is locked, and rst_req, smr_req and irq are low.
- R2: A write of 0x55 to address 0 followed directly by a write of 0xAA to address 0 unlocks the reload bytes. Neither key write changes the value read from address 0.
- R3: Once unlocked, writes to address 1 (upper byte, bits 23:16), then address 2 (bits 15:8), then address 3 (bits 7:0) store those bytes. The write to address 3 relocks the protection.
- R4: Any write that does not fit the expected step relocks the protection, including a wrong address, a wrong key value, or a second 0x55. Reads on the bus never disturb the sequence.
- R5: Writes to addresses 1 to 3 while the protection is locked leave the reload value unchanged.
- R6: The counter loads the reload value in the cycle after enable rises and in the cycle after each refresh pulse.
- R7: While enabled, the counter decrements once per tick and holds when tick is low. A tick at zero is a time-out and reloads the counter, so the first request appears reload+1 ticks after the load.
- R8: In reset mode (mode_irq=0) with stop_mode low, a time-out gives a one-cycle rst_req pulse and sets control bit 7.
- R9: In reset mode with stop_mode high, a time-out gives a one-cycle smr_req pulse and sets control bits 7 and 6. rst_req stays low.
- R10: With mode_irq=1, a time-out gives a one-cycle irq pulse. No reset request is raised and the control bits are left unchanged.
- R11: A read of address 0 returns the status bits and clears bits 7 and 6 for the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one decrement per high cycle |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Bus address: 0 control, 1 to 3 reload bytes |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data for addr (combinational) |
| enable | input | 1 | Watchdog on |
| refresh | input | 1 | Restart pulse; reloads the counter |
| stop_mode | input | 1 | System is in stop mode |
| mode_irq | input | 1 | 1 selects interrupt on time-out, 0 selects reset |
| rst_req | output | 1 | Normal reset request pulse |
| smr_req | output | 1 | Stop-recovery request pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
The unlock logic is driven by a table of write and read-back steps. It includes a correct sequence, a sequence with bytes out of order, a foreign write placed between the keys, a repeated first key, and reads placed inside an open sequence. Each case shows whether one specific kind of break relocks the protection, which a lock that only watched addresses or only watched data would get wrong. The counter is then run with a small reload in the three time-out modes, with frequent refresh, and with tick held low. These runs separate the load, count and hold behaviour and check which request line fires.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_KEY1, LK_OPEN} lock_e;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock import wdog_pkg::*; #(
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 8 * NBYTES,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [CNT_W-1:0]  reload,
  output lock_e             lock_st
);
  lock_e             st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              addr_ok, last;

  assign addr_ok = (addr == ADDR_W'(idx_q) + ADDR_W'(1));
  assign last    = (idx_q == IDX_W'(NBYTES - 1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (wr_en) begin
      case (st_q)
        LK_IDLE: if (addr == '0 && wdata == KEY_FIRST) st_d = LK_KEY1;
        LK_KEY1: begin
          idx_d = '0;
          st_d  = (addr == '0 && wdata == KEY_SECOND) ? LK_OPEN : LK_IDLE;
        end
        LK_OPEN: begin
          if (addr_ok && !last) idx_d = idx_q + IDX_W'(1);
          else begin
            idx_d = '0;
            st_d  = LK_IDLE;
          end
        end
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [7:0] byte_q;
    logic       we;
    assign we = wr_en && st_q == LK_OPEN && addr_ok && idx_q == IDX_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= 8'hFF;
      else if (we) byte_q <= wdata;
    end
    assign reload[CNT_W-1-8*i -: 8] = byte_q;
  end

  assign lock_st = st_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             refresh,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             expire,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  assign load   = (enable && !en_q) || refresh;
  assign expire = enable && tick && !load && cnt_q == '0;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = reload;
    else if (enable && tick)    cnt_d = (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= enable;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic mode_irq,
  input  logic stop_mode,
  input  logic rd_clr,
  output logic rst_req,
  output logic smr_req,
  output logic irq,
  output logic status_q,
  output logic stop_q
);
  logic rst_d, smr_d, irq_d, status_d, stop_d, rst_path;

  assign rst_path = expire && !mode_irq;

  always_comb begin
    rst_d    = rst_path && !stop_mode;
    smr_d    = rst_path && stop_mode;
    irq_d    = expire && mode_irq;
    status_d = rst_path ? 1'b1 : (rd_clr ? 1'b0 : status_q);
    stop_d   = smr_d    ? 1'b1 : (rd_clr ? 1'b0 : stop_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      smr_req  <= 1'b0;
      irq      <= 1'b0;
      status_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      rst_req  <= rst_d;
      smr_req  <= smr_d;
      irq      <= irq_d;
      status_q <= status_d;
      stop_q   <= stop_d;
    end
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard import wdog_pkg::*; #(
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              enable,
  input  logic              refresh,
  input  logic              stop_mode,
  input  logic              mode_irq,
  output logic              rst_req,
  output logic              smr_req,
  output logic              irq
);
  localparam int CNT_W = 8 * NBYTES;

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic [CNT_W-1:0] reload, cnt;
  lock_e            lock_st;
  logic             expire, en_q, status_q, stop_q, rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign rd_clr = rd_en && addr == '0;

  wdog_lock #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) i_lock (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .reload(reload), .lock_st(lock_st));

  wdog_count #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rst_n(rst_sn), .enable(enable), .refresh(refresh), .tick(tick),
    .reload(reload), .expire(expire), .en_q(en_q), .cnt(cnt));

  wdog_status i_status (
    .clk(clk), .rst_n(rst_sn), .expire(expire), .mode_irq(mode_irq),
    .stop_mode(stop_mode), .rd_clr(rd_clr), .rst_req(rst_req),
    .smr_req(smr_req), .irq(irq), .status_q(status_q), .stop_q(stop_q));

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = {status_q, stop_q, 6'b0};
    for (int i = 0; i < NBYTES; i++)
      if (addr == ADDR_W'(i + 1)) rdata = reload[CNT_W-1-8*i -: 8];
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk import wdog_pkg::*; #(
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 8 * NBYTES
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              enable,
  input logic              refresh,
  input logic              stop_mode,
  input logic              mode_irq,
  input logic              rst_req,
  input logic              smr_req,
  input logic              irq,
  input lock_e             lock_st,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  cnt,
  input logic              expire,
  input logic              en_q,
  input logic              status_q,
  input logic              stop_q
);
  p_req_onehot_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({rst_req, smr_req, irq}));

  p_rst_normal_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    rst_req |-> (!$past(stop_mode) && !$past(mode_irq) && status_q));

  p_smr_stop_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    smr_req |-> ($past(stop_mode) && !$past(mode_irq) && status_q && stop_q));

  p_irq_mode_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> $past(mode_irq));

  p_locked_reload_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (lock_st != LK_OPEN) |=> $stable(reload));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (enable && en_q && !tick && !refresh) |=> (cnt == $past(cnt)));

  p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && addr == '0 && !expire) |=> (!status_q && !stop_q));
endmodule

bind wdog_guard wdog_guard_chk #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_sn(rst_sn), .tick(tick), .rd_en(rd_en), .addr(addr),
  .enable(enable), .refresh(refresh), .stop_mode(stop_mode), .mode_irq(mode_irq),
  .rst_req(rst_req), .smr_req(smr_req), .irq(irq), .lock_st(lock_st),
  .reload(reload), .cnt(cnt), .expire(expire), .en_q(en_q),
  .status_q(status_q), .stop_q(stop_q));

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
  logic       clk, rst_n, tick, wr_en, rd_en, enable, refresh, stop_mode, mode_irq;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       rst_req, smr_req, irq;
  int         errors = 0, checks = 0;

  wdog_guard i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .enable(enable), .refresh(refresh),
    .stop_mode(stop_mode), .mode_irq(mode_irq), .rst_req(rst_req),
    .smr_req(smr_req), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed { logic wr; logic [1:0] a; logic [7:0] d; } op_t;
  localparam int NOPS = 45;
  localparam op_t OPS [NOPS] = '{
    // 0..5 R1 reset contents, R5 locked write ignored
    '{1'b0,2'd1,8'hFF}, '{1'b0,2'd2,8'hFF}, '{1'b0,2'd3,8'hFF}, '{1'b0,2'd0,8'h00},
    '{1'b1,2'd1,8'h12}, '{1'b0,2'd1,8'hFF},
    // 6..15 R2 key, R3 ordered bytes
    '{1'b1,2'd0,8'h55}, '{1'b1,2'd0,8'hAA}, '{1'b0,2'd0,8'h00}, '{1'b1,2'd1,8'h12},
    '{1'b1,2'd2,8'h34}, '{1'b1,2'd3,8'h56}, '{1'b0,2'd1,8'h12}, '{1'b0,2'd2,8'h34},
    '{1'b0,2'd3,8'h56}, '{1'b0,2'd0,8'h00},
    // 16..17 R3 relock after low byte
    '{1'b1,2'd1,8'h99}, '{1'b0,2'd1,8'h12},
    // 18..23 R4 out of order
    '{1'b1,2'd0,8'h55}, '{1'b1,2'd0,8'hAA}, '{1'b1,2'd2,8'h77}, '{1'b1,2'd1,8'h77},
    '{1'b0,2'd1,8'h12}, '{1'b0,2'd2,8'h34},
    // 24..29 R4 foreign write between keys
    '{1'b1,2'd0,8'h55}, '{1'b1,2'd3,8'h00}, '{1'b1,2'd0,8'hAA}, '{1'b1,2'd1,8'h77},
    '{1'b0,2'd1,8'h12}, '{1'b0,2'd3,8'h56},
    // 30..34 R4 repeated first key
    '{1'b1,2'd0,8'h55}, '{1'b1,2'd0,8'h55}, '{1'b1,2'd0,8'hAA}, '{1'b1,2'd1,8'h77},
    '{1'b0,2'd1,8'h12},
    // 35..44 R4 reads inside an open sequence
    '{1'b1,2'd0,8'h55}, '{1'b0,2'd1,8'h12}, '{1'b1,2'd0,8'hAA}, '{1'b0,2'd0,8'h00},
    '{1'b1,2'd1,8'h00}, '{1'b1,2'd2,8'h00}, '{1'b1,2'd3,8'h03}, '{1'b0,2'd1,8'h00},
    '{1'b0,2'd2,8'h00}, '{1'b0,2'd3,8'h03}
  };

  function automatic string tag_of(input int i);
    if (i < 4)       return "R1";
    else if (i < 6)  return "R5";
    else if (i < 9)  return "R2";
    else if (i < 18) return "R3";
    else             return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    rd_en = 1'b1; addr = a;
    #1 check(req, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // restart enable and record the first negedge index and count of each request
  task automatic run_en(input int n, output int f_rst, output int n_rst,
                        output int f_smr, output int n_smr,
                        output int f_irq, output int n_irq);
    f_rst = 0; n_rst = 0; f_smr = 0; n_smr = 0; f_irq = 0; n_irq = 0;
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (rst_req) begin n_rst++; if (f_rst == 0) f_rst = k; end
      if (smr_req) begin n_smr++; if (f_smr == 0) f_smr = k; end
      if (irq)     begin n_irq++; if (f_irq == 0) f_irq = k; end
    end
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int fr, nr, fs, ns, fi, ni, hits;
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    enable = 1'b0; refresh = 1'b0; stop_mode = 1'b0; mode_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs", {rst_req, smr_req, irq}, 0);

    for (int i = 0; i < NOPS; i++) begin
      if (OPS[i].wr) wr(OPS[i].a, OPS[i].d);
      else           rd(OPS[i].a, OPS[i].d, tag_of(i));
    end
    // reload is now 0x000003

    // R8 normal reset: load, 3 decrements, time-out at the 4th tick
    run_en(6, fr, nr, fs, ns, fi, ni);
    check("R7 first request index", fr, 5);
    check("R8 rst_req pulse count", nr, 1);
    check("R8 no smr/irq", ns + ni, 0);
    rd(2'd0, 8'h80, "R8");
    rd(2'd0, 8'h00, "R11");

    // R9 stop mode
    stop_mode = 1'b1;
    run_en(6, fr, nr, fs, ns, fi, ni);
    check("R9 smr_req index", fs, 5);
    check("R9 smr_req count", ns, 1);
    check("R9 no rst_req", nr, 0);
    rd(2'd0, 8'hC0, "R9");
    rd(2'd0, 8'h00, "R11");
    stop_mode = 1'b0;

    // R10 interrupt mode
    mode_irq = 1'b1;
    run_en(6, fr, nr, fs, ns, fi, ni);
    check("R10 irq index", fi, 5);
    check("R10 irq count", ni, 1);
    check("R10 no reset request", nr + ns, 0);
    rd(2'd0, 8'h00, "R10");
    mode_irq = 1'b0;

    // R7 reload after time-out: second request 4 ticks after the first
    run_en(10, fr, nr, fs, ns, fi, ni);
    check("R7 periodic count", nr, 2);
    rd(2'd0, 8'h00 | 8'h80, "R8 status");

    // R6 refresh every other cycle prevents time-out
    enable = 1'b1;
    hits = 0;
    for (int k = 0; k < 24; k++) begin
      refresh = (k % 2 == 0);
      @(negedge clk);
      if (rst_req) hits++;
    end
    refresh = 1'b0;
    check("R6 refresh keeps quiet", hits, 0);
    enable = 1'b0;
    @(negedge clk);

    // R7 hold while tick low, then 4 ticks to time-out
    tick = 1'b0;
    enable = 1'b1;
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
    check("R7 no count without tick", hits, 0);
    tick = 1'b1;
    fr = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (rst_req && fr == 0) fr = k;
    end
    check("R7 resume after hold", fr, 4);
    enable = 1'b0;
    @(negedge clk);
    rd(2'd0, 8'h80, "R11 read value");
    rd(2'd0, 8'h00, "R11 cleared");

    // R1 reset relocks an open sequence and restores all ones
    wr(2'd0, 8'h55);
    wr(2'd0, 8'hAA);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h11);
    rd(2'd1, 8'hFF, "R1 relock");
    rd(2'd3, 8'hFF, "R1 reload ones");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule